// File: doc/BRIEF.md
# Two-Phase Transition-Handshake Pipeline

This block is a short chain of pipeline stages that move a data word with a two-phase handshake. Request and acknowledge are toggle signals: every change of level, rising or falling, is one event, and there is no return-to-zero phase between transfers. The design is modelled synchronously. Each toggle input is sampled by a register, and an event is the XOR of a toggle's current and last recorded value.

Each stage holds a join gate of the Muller type and a capture/pass register. The join fires only when a fresh upstream request has arrived and the stage's earlier word has been released downstream. Its output toggle tells the register to capture the input word. When the word is held, the register toggles a capture-done line. That line is the stage's acknowledge to the left and its request to the right. A downstream acknowledge is the pass event. It reopens the register, and a pass-done toggle then re-arms the join.

The sender must hold the word steady from the moment it toggles the request until the acknowledge toggles. The receiver must take the word before it toggles its acknowledge.

Top module: `toggle_pipe`

## Requirements
- R1: After reset, `up_ack` and `dn_req` are 0 and every register is open, so `dn_data` equals `up_data` while no word is in flight (default `OPEN_FLOW`=1).
- R2: Each toggle of `up_req`, whether 0 to 1 or 1 to 0, transfers exactly one word, and `up_ack` toggles exactly once for that word.
- R3: `dn_req` toggles only when `dn_req` equalled `dn_ack` in the cycle before, meaning the previous word was acknowledged.
- R4: Words leave at `dn_data` in the order they entered, with none lost and none duplicated.
- R5: While `dn_req` differs from `dn_ack`, `dn_data` does not change.
- R6: `up_ack` toggles only when `up_req` differed from `up_ack` in the cycle before.
- R7: If downstream stops acknowledging, the chain accepts exactly `STAGES` words and then holds `up_ack` equal to its last value.
- R8: In an empty chain, `up_ack` toggles 3 clock edges after a `up_req` toggle, and `dn_req` toggles 3×`STAGES` edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req | input | 1 | Upstream request toggle |
| up_ack | output | 1 | Upstream acknowledge toggle (capture-done of first stage) |
| up_data | input | WIDTH | Upstream data word |
| dn_req | output | 1 | Downstream request toggle (capture-done of last stage) |
| dn_ack | input | 1 | Downstream acknowledge toggle |
| dn_data | output | WIDTH | Downstream data word |

## Verification
The bench builds the chain with `WIDTH`=8, `STAGES`=3 and an open-flow register. With 8 bits, a stream of 256 words can carry every possible value once. That stream runs through the chain with back-to-back handshakes, so request and acknowledge toggle in both directions many times. A second stream uses computed irregular gaps on both sides, which keeps the data-hold window open for several cycles. With three stages, filling the chain against a stalled receiver takes only a few words, and the 3-edge-per-stage latency can be counted exactly.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
   typedef enum logic {
      LM_OPEN = 1'b0,
      LM_HELD = 1'b1
   } latch_mode_e;

   // one event per change of a toggle relative to its recorded level
   function automatic logic tgl_event(input logic cur, input logic seen);
      return cur ^ seen;
   endfunction
endpackage

// File: rtl/tp_cjoin.sv
`timescale 1ns/1ps
// Registered Muller-type join: output follows the inputs only once they agree.
module tp_cjoin #(
   parameter int unsigned N_IN = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_IN-1:0] ins,
   output logic            c
);
   if (N_IN < 2) begin : g_bad_n
      $error("tp_cjoin: N_IN must be at least 2");
   end

   logic all_hi, all_lo, c_q;

   assign all_hi = &ins;
   assign all_lo = ~|ins;

   always_ff @(posedge clk) begin
      if (rst)         c_q <= 1'b0;
      else if (all_hi) c_q <= 1'b1;
      else if (all_lo) c_q <= 1'b0;
   end

   assign c = c_q;
endmodule

// File: rtl/tp_cp_latch.sv
`timescale 1ns/1ps
// Capture/pass register: capture and pass are toggles, either edge counts.
module tp_cp_latch
   import tp_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter bit          OPEN_FLOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_tgl,
   input  logic             pass_tgl,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic             cap_done,
   output logic             pass_done
);
   latch_mode_e      mode_q;
   logic [WIDTH-1:0] word_q;
   logic             cap_done_q, pass_done_q;
   logic             cap_ev, pass_ev;

   assign cap_ev  = tgl_event(cap_tgl, cap_done_q);
   assign pass_ev = tgl_event(pass_tgl, pass_done_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q      <= LM_OPEN;
         word_q      <= '0;
         cap_done_q  <= 1'b0;
         pass_done_q <= 1'b0;
      end else begin
         if (pass_ev) begin
            mode_q      <= LM_OPEN;
            pass_done_q <= pass_tgl;
         end
         if (cap_ev) begin
            mode_q     <= LM_HELD;
            word_q     <= d;
            cap_done_q <= cap_tgl;
         end
      end
   end

   if (OPEN_FLOW) begin : g_open_flow
      // transparent when open: the output follows the input word
      assign q = (mode_q == LM_HELD) ? word_q : d;
   end else begin : g_reg_only
      assign q = word_q;
   end

   assign cap_done  = cap_done_q;
   assign pass_done = pass_done_q;
endmodule

// File: rtl/tp_stage.sv
`timescale 1ns/1ps
module tp_stage #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          OPEN_FLOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             l_req,
   output logic             l_ack,
   input  logic [WIDTH-1:0] l_data,
   output logic             r_req,
   input  logic             r_ack,
   output logic [WIDTH-1:0] r_data
);
   logic req_s, ack_s;
   logic fire, cap_done, pass_done;

   // sampling registers for the incoming toggles
   always_ff @(posedge clk) begin
      if (rst) begin
         req_s <= 1'b0;
         ack_s <= 1'b0;
      end else begin
         req_s <= l_req;
         ack_s <= r_ack;
      end
   end

   // join new request with inverted pass-done (previous word released)
   tp_cjoin #(.N_IN(2)) u_join (
      .clk (clk),
      .rst (rst),
      .ins ({req_s, ~pass_done}),
      .c   (fire)
   );

   tp_cp_latch #(.WIDTH(WIDTH), .OPEN_FLOW(OPEN_FLOW)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .cap_tgl   (fire),
      .pass_tgl  (ack_s),
      .d         (l_data),
      .q         (r_data),
      .cap_done  (cap_done),
      .pass_done (pass_done)
   );

   assign l_ack = cap_done;
   assign r_req = cap_done;
endmodule

// File: rtl/toggle_pipe.sv
`timescale 1ns/1ps
module toggle_pipe #(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned STAGES    = 3,
   parameter bit          OPEN_FLOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up_req,
   output logic             up_ack,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_req,
   input  logic             dn_ack,
   output logic [WIDTH-1:0] dn_data
);
   localparam int unsigned NODES = STAGES + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("toggle_pipe: WIDTH must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("toggle_pipe: STAGES must be at least 1");
   end

   logic             req_n  [NODES];
   logic             ack_n  [NODES];
   logic [WIDTH-1:0] data_n [NODES];

   assign req_n[0]       = up_req;
   assign data_n[0]      = up_data;
   assign ack_n[STAGES]  = dn_ack;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      tp_stage #(.WIDTH(WIDTH), .OPEN_FLOW(OPEN_FLOW)) u_stage (
         .clk    (clk),
         .rst    (rst),
         .l_req  (req_n[i]),
         .l_ack  (ack_n[i]),
         .l_data (data_n[i]),
         .r_req  (req_n[i+1]),
         .r_ack  (ack_n[i+1]),
         .r_data (data_n[i+1])
      );
   end

   assign up_ack  = ack_n[0];
   assign dn_req  = req_n[STAGES];
   assign dn_data = data_n[STAGES];
endmodule

// File: rtl/toggle_pipe_chk.sv
`timescale 1ns/1ps
module toggle_pipe_chk #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             up_req,
   input logic             up_ack,
   input logic             dn_req,
   input logic             dn_ack,
   input logic [WIDTH-1:0] dn_data
);
   localparam int unsigned OCC_W = $clog2(STAGES + 2) + 1;

   logic             up_ack_q, dn_req_q;
   logic [OCC_W-1:0] occ_q;

   // words accepted upstream but not yet offered downstream
   always_ff @(posedge clk) begin
      if (rst) begin
         up_ack_q <= 1'b0;
         dn_req_q <= 1'b0;
         occ_q    <= '0;
      end else begin
         up_ack_q <= up_ack;
         dn_req_q <= dn_req;
         occ_q    <= occ_q + OCC_W'(up_ack ^ up_ack_q) - OCC_W'(dn_req ^ dn_req_q);
      end
   end

   p_req_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
      (dn_req != $past(dn_req)) |-> ($past(dn_req) == $past(dn_ack)));

   p_hold_data_r5: assert property (@(posedge clk) disable iff (rst)
      ((dn_req != dn_ack) && $past(dn_req != dn_ack)) |-> $stable(dn_data));

   p_ack_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
      (up_ack != $past(up_ack)) |-> ($past(up_req) != $past(up_ack)));

   p_occupancy_r7: assert property (@(posedge clk) disable iff (rst)
      occ_q <= OCC_W'(STAGES));
endmodule

bind toggle_pipe toggle_pipe_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .up_req  (up_req),
   .up_ack  (up_ack),
   .dn_req  (dn_req),
   .dn_ack  (dn_ack),
   .dn_data (dn_data)
);

// File: tb/toggle_pipe_bench.sv
`timescale 1ns/1ps
module toggle_pipe_bench;
   localparam int unsigned WIDTH  = 8;
   localparam int unsigned STAGES = 3;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             up_req = 1'b0;
   logic             up_ack;
   logic [WIDTH-1:0] up_data = '0;
   logic             dn_req;
   logic             dn_ack = 1'b0;
   logic [WIDTH-1:0] dn_data;

   int n_checks = 0;
   int n_fail   = 0;
   int accepted = 0;
   int finished = 0;

   always #2.5 clk = ~clk;

   toggle_pipe #(.WIDTH(WIDTH), .STAGES(STAGES), .OPEN_FLOW(1'b1)) u_toggle_pipe (
      .clk     (clk),
      .rst     (rst),
      .up_req  (up_req),
      .up_ack  (up_ack),
      .up_data (up_data),
      .dn_req  (dn_req),
      .dn_ack  (dn_ack),
      .dn_data (dn_data)
   );

   function automatic logic [WIDTH-1:0] word_of(input int phase, input int k);
      return WIDTH'((k * 167 + phase * 59) & 255);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // R2/R6: one toggle of up_req per word, wait for the acknowledge toggle
   task automatic send(input int n, input int phase, input bit gaps);
      for (int k = 0; k < n; k++) begin
         up_data = word_of(phase, k);
         @(negedge clk);
         up_req = ~up_req;
         while (up_ack != up_req) @(negedge clk);
         accepted++;
         if (gaps) repeat ((k * 3) % 4) @(negedge clk);
      end
   endtask

   // R4/R5: take each word in order, hold the handshake open, then acknowledge
   task automatic recv(input int n, input int phase, input bit gaps);
      for (int k = 0; k < n; k++) begin
         logic [WIDTH-1:0] got;
         int moved;
         while (dn_req == dn_ack) @(negedge clk);
         got = dn_data;
         check("R4 order/no loss", int'(got), int'(word_of(phase, k)));
         moved = 0;
         if (gaps) begin
            for (int d = 0; d < (k * 5 + 1) % 7; d++) begin
               @(negedge clk);
               if (dn_data != got) moved = 1;
            end
         end
         check("R5 data held while req pending", moved, 0);
         dn_ack = ~dn_ack;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      int ack_lat, fwd_lat;
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R1: reset state and open registers
      up_data = 8'h5A;
      @(negedge clk);
      check("R1 up_ack after reset", int'(up_ack), 0);
      check("R1 dn_req after reset", int'(dn_req), 0);
      check("R1 open flow dn_data", int'(dn_data), 8'h5A);

      // R8: latency through an empty chain (rising toggle)
      up_data = 8'hC3;
      @(negedge clk);
      up_req  = 1'b1;
      ack_lat = 0;
      fwd_lat = 0;
      for (int c = 1; c <= 40 && fwd_lat == 0; c++) begin
         @(negedge clk);
         if (ack_lat == 0 && up_ack == up_req) ack_lat = c;
         if (dn_req != dn_ack) fwd_lat = c;
      end
      check("R8 up_ack latency", ack_lat, 3);
      check("R8 dn_req latency", fwd_lat, 3 * STAGES);
      check("R4 latency word", int'(dn_data), 8'hC3);
      dn_ack = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 single transfer, no extra req", int'(dn_req == dn_ack), 1);

      // R2/R4/R5: every 8-bit value once, back-to-back handshakes
      fork
         send(256, 1, 1'b0);
         recv(256, 1, 1'b0);
      join

      // R4/R5: irregular gaps on both sides
      fork
         send(64, 2, 1'b1);
         recv(64, 2, 1'b1);
      join

      // R7: stalled receiver, the chain fills to exactly STAGES words
      accepted = 0;
      fork
         send(STAGES + 1, 3, 1'b0);
      join_none
      repeat (60) @(negedge clk);
      check("R7 words accepted while stalled", accepted, STAGES);
      check("R7 up_ack frozen (pending req)", int'(up_req != up_ack), 1);
      recv(STAGES + 1, 3, 1'b0);
      wait fork;
      check("R7 all words accepted after drain", accepted, STAGES + 1);

      repeat (10) @(negedge clk);
      check("R2 idle handshake levels match", int'(dn_req == dn_ack && up_req == up_ack), 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule